// File: doc/BRIEF.md
# Majority-Clocked Triple-Register Keystream Generator

This block produces a bit-serial keystream from three short linear feedback shift registers whose stepping is irregular. Each register exposes one clock-control bit. On every keystream or warm-up step, a register advances only when its control bit agrees with the majority of the three control bits, so at least two registers move on each such step. A 64-bit secret key and then a 22-bit frame number are written one bit per cycle through a valid/ready load port. During loading every register advances and takes the incoming bit into its input end. Next come 100 warm-up steps whose output is discarded. After that the block encrypts or decrypts one data bit per accepted transfer: the keystream bit is XORed with the input data bit.

The controller is a five-state machine:
- IDLE waits for the first load bit after reset.
- KEY takes the key bits.
- FRAME takes the frame bits.
- WARM runs the discarded steps.
- RUN streams data.

Its transitions are:
- IDLE to KEY, and RUN to KEY, on an accepted load bit. This is the start or restart of a load, and the accepted bit is key bit 0.
- KEY to FRAME after the 64th key bit.
- FRAME to WARM after the 22nd frame bit.
- WARM to RUN after the 100th warm-up step.

With an unbroken load stream the keystream becomes available 186 clock edges after the first load bit.

Top module: `mv_keystream`

## Requirements
- R1: After reset all three registers are zero, `ks_live`, `din_ready` and `dout_valid` are low, and `ld_ready` is high.
- R2: A load bit accepted while idle or while streaming clears all three registers before that bit is applied, starts a new load, and drops `ks_live` from the next clock edge until setup completes again.
- R3: Each accepted load bit steps all three registers and XORs the bit into bit 0 of each. The 64 key bits come least significant first, then the 22 frame bits least significant first. A cycle without an accepted bit leaves the state unchanged.
- R4: The registers are 19, 22 and 23 bits long, with bit 0 as the input end. Each register shifts toward its MSB and takes into bit 0 the XOR of its taps: {18,17,16,13}, {21,20} and {22,21,20,7}.
- R5: After the 86th load bit the block runs exactly 100 warm-up steps with `ld_ready` low. Load bits offered during that time are ignored. `ks_live` rises on the 100th warm-up edge.
- R6: In a warm-up or keystream step, a register advances only if its control bit equals the majority of the three control bits. The control bits are bit 8, bit 10 and bit 10 of the three registers.
- R7: `dout` equals `din` XOR the keystream bit. The keystream bit is the XOR of the three register MSBs in the current state, and it is combinational from that state.
- R8: `dout_valid` = `din_valid` AND `ks_live`, and `din_ready` = `ks_live` AND `dout_ready`. The registers step only when a data bit is transferred, so a stalled output keeps the pending keystream bit.
- R9: An all-zero key and frame leave every register at zero, so `dout` equals `din` on every transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ld_bit | input | 1 | Key or frame bit being loaded |
| ld_valid | input | 1 | Load bit offered |
| ld_ready | output | 1 | Load bit can be taken (low during warm-up) |
| din | input | 1 | Data bit to combine with the keystream |
| din_valid | input | 1 | Data bit offered |
| din_ready | output | 1 | Data bit taken this cycle |
| dout | output | 1 | Data XOR keystream |
| dout_valid | output | 1 | Output bit valid |
| dout_ready | input | 1 | Consumer accepts the output bit |
| ks_live | output | 1 | Setup complete, keystream available |

## Verification
The combined output bit is combinational: it is due in the same cycle that data is presented, and the state advances at the following edge. The bench therefore drives on the falling edge, samples 1 ns later, and only then advances its reference model. `ks_live` is due exactly 100 edges after the edge that takes the last frame bit, and it falls one edge after a restarting load bit. The bench counts falling edges from those points and samples at 99 and 100 warm-up edges to pin the rise to a single cycle. Stalls, gaps in the load stream and load bits offered during warm-up must not shift the model's state, and this is confirmed by the keystream that follows them.

// File: rtl/mv_pkg.sv
package mv_pkg;
    localparam int unsigned KEY_W   = 64;
    localparam int unsigned FRAME_W = 22;
    localparam int unsigned WARM_N  = 100;
    localparam int unsigned NREG    = 3;
    localparam int unsigned MAX_LEN = 23;
    localparam int unsigned CNT_W   = $clog2(KEY_W + FRAME_W + WARM_N);

    localparam int unsigned REG_LEN [NREG] = '{19, 22, 23};
    localparam int unsigned REG_CTL [NREG] = '{8, 10, 10};
    localparam logic [MAX_LEN-1:0] REG_TAP [NREG] = '{23'h072000, 23'h300000, 23'h700080};

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_KEY,
        ST_FRAME,
        ST_WARM,
        ST_RUN
    } mv_state_e;
endpackage

// File: rtl/mv_lfsr.sv
module mv_lfsr #(
    parameter int unsigned LEN  = 19,
    parameter int unsigned W    = 23,
    parameter logic [W-1:0] TAPS = '0,
    parameter int unsigned CTAP = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic         inj,
    input  logic         step,
    output logic         ctl,
    output logic         msb,
    output logic [W-1:0] q
);
    logic [LEN-1:0] r;
    logic [LEN-1:0] base;
    logic           fb_base;
    logic           fb_run;

    always_comb begin
        base    = clr ? '0 : r;
        fb_base = ^(base & TAPS[LEN-1:0]);
        fb_run  = ^(r & TAPS[LEN-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r <= '0;
        else if (load)
            r <= {base[LEN-2:0], fb_base ^ inj};
        else if (step)
            r <= {r[LEN-2:0], fb_run};
    end

    assign ctl = r[CTAP];
    assign msb = r[LEN-1];
    assign q   = W'(r);

    AST_CLR_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (load && clr) |=> (r[LEN-1:1] == '0) && (r[0] == $past(inj))); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> $stable(r)); // R3
endmodule

// File: rtl/mv_majority.sv
module mv_majority #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] cbits,
    output logic [N-1:0] adv
);
    logic maj;

    always_comb begin
        maj = (cbits[0] & cbits[1]) | (cbits[0] & cbits[2]) | (cbits[1] & cbits[2]);
    end

    for (genvar g = 0; g < N; g++) begin : g_adv
        assign adv[g] = (cbits[g] == maj);
    end

    AST_TWO_ADVANCE: assert final ($countones(adv) >= 2); // R6
endmodule

// File: rtl/mv_ctrl.sv
module mv_ctrl
    import mv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_valid,
    input  logic xfer,
    output logic ld_ready,
    output logic ks_live,
    output logic load_step,
    output logic load_clr,
    output logic maj_en
);
    mv_state_e        state, state_n;
    logic [CNT_W-1:0] cnt, cnt_n;
    logic             accept;

    assign accept = ld_valid && ld_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_comb begin
        state_n = state;
        cnt_n   = cnt;
        unique case (state)
            ST_IDLE, ST_RUN: begin
                if (accept) begin
                    state_n = ST_KEY;
                    cnt_n   = CNT_W'(1);
                end
            end
            ST_KEY: begin
                if (accept) begin
                    if (cnt == CNT_W'(KEY_W - 1)) begin
                        state_n = ST_FRAME;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_FRAME: begin
                if (accept) begin
                    if (cnt == CNT_W'(FRAME_W - 1)) begin
                        state_n = ST_WARM;
                        cnt_n   = '0;
                    end else begin
                        cnt_n = cnt + 1'b1;
                    end
                end
            end
            ST_WARM: begin
                if (cnt == CNT_W'(WARM_N - 1)) begin
                    state_n = ST_RUN;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt + 1'b1;
                end
            end
            default: begin
                state_n = ST_IDLE;
                cnt_n   = '0;
            end
        endcase
    end

    always_comb begin
        ld_ready  = (state != ST_WARM);
        ks_live   = (state == ST_RUN);
        load_step = accept;
        load_clr  = accept && ((state == ST_IDLE) || (state == ST_RUN));
        maj_en    = (state == ST_WARM) || ((state == ST_RUN) && xfer && !accept);
    end

    AST_LIVE_AFTER_WARM: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ks_live) |-> ($past(state) == ST_WARM) && ($past(cnt) == CNT_W'(WARM_N - 1))); // R5

    AST_WARM_BLOCKS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WARM) |=> (state == ST_WARM) || (state == ST_RUN)); // R5
endmodule

// File: rtl/mv_keystream.sv
module mv_keystream
    import mv_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ld_bit,
    input  logic ld_valid,
    output logic ld_ready,
    input  logic din,
    input  logic din_valid,
    output logic din_ready,
    output logic dout,
    output logic dout_valid,
    input  logic dout_ready,
    output logic ks_live
);
    logic               load_step, load_clr, maj_en, xfer, ks_bit;
    logic [NREG-1:0]    cbits, adv, msbs;
    logic [MAX_LEN-1:0] q [NREG];

    assign din_ready  = ks_live && dout_ready;
    assign dout_valid = din_valid && ks_live;
    assign xfer       = din_valid && din_ready;
    assign ks_bit     = ^msbs;
    assign dout       = din ^ ks_bit;

    mv_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ld_valid  (ld_valid),
        .xfer      (xfer),
        .ld_ready  (ld_ready),
        .ks_live   (ks_live),
        .load_step (load_step),
        .load_clr  (load_clr),
        .maj_en    (maj_en)
    );

    mv_majority #(.N(NREG)) u_maj (
        .cbits (cbits),
        .adv   (adv)
    );

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        mv_lfsr #(
            .LEN  (REG_LEN[g]),
            .W    (MAX_LEN),
            .TAPS (REG_TAP[g]),
            .CTAP (REG_CTL[g])
        ) u_lfsr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (load_step),
            .clr   (load_clr),
            .inj   (ld_bit),
            .step  (maj_en && adv[g]),
            .ctl   (cbits[g]),
            .msb   (msbs[g]),
            .q     (q[g])
        );
    end

    AST_STALL_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
        (ks_live && din_valid && !dout_ready && !ld_valid)
        |=> $stable(q[0]) && $stable(q[1]) && $stable(q[2])); // R8

    AST_OUT_NEEDS_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        dout_valid |-> ks_live && din_valid); // R8

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !ks_live && (q[0] == '0) && (q[1] == '0) && (q[2] == '0)); // R1
endmodule

// File: tb/mv_keystream_tb.sv
module mv_keystream_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ld_bit = 1'b0, ld_valid = 1'b0, ld_ready;
    logic din = 1'b0, din_valid = 1'b0, din_ready;
    logic dout, dout_valid, dout_ready = 1'b0, ks_live;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [18:0] m1;
    logic [21:0] m2;
    logic [22:0] m3;

    // key[117:54], frame[53:32], data[31:0]
    localparam logic [117:0] VEC [4] = '{
        {64'h0123_4567_89AB_CDEF, 22'h000134, 32'hDEAD_BEEF},
        {64'hFFFF_FFFF_FFFF_FFFF, 22'h3FFFFF, 32'h0000_0000},
        {64'h8000_0000_0000_0001, 22'h000001, 32'hFFFF_FFFF},
        {64'h0000_0000_0000_0000, 22'h000000, 32'hA5C3_0F96}
    };

    always #2 clk = ~clk;

    mv_keystream u_dut (
        .clk(clk), .rst_n(rst_n), .ld_bit(ld_bit), .ld_valid(ld_valid), .ld_ready(ld_ready),
        .din(din), .din_valid(din_valid), .din_ready(din_ready), .dout(dout),
        .dout_valid(dout_valid), .dout_ready(dout_ready), .ks_live(ks_live)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic m_out();
        return m1[18] ^ m2[21] ^ m3[22];
    endfunction

    task automatic m_load(input logic b);
        m1 = {m1[17:0], m1[18] ^ m1[17] ^ m1[16] ^ m1[13] ^ b};
        m2 = {m2[20:0], m2[21] ^ m2[20] ^ b};
        m3 = {m3[21:0], m3[22] ^ m3[21] ^ m3[20] ^ m3[7] ^ b};
    endtask

    task automatic m_step();
        logic a, b, c, mj;
        a = m1[8]; b = m2[10]; c = m3[10];
        mj = (a & b) | (a & c) | (b & c);
        if (a == mj) m1 = {m1[17:0], m1[18] ^ m1[17] ^ m1[16] ^ m1[13]};
        if (b == mj) m2 = {m2[20:0], m2[21] ^ m2[20]};
        if (c == mj) m3 = {m3[21:0], m3[22] ^ m3[21] ^ m3[20] ^ m3[7]};
    endtask

    task automatic load(input logic [63:0] key, input logic [21:0] frame,
                        input bit gap, input bit poke_warm);
        m1 = '0; m2 = '0; m3 = '0;
        for (int i = 0; i < 86; i++) begin
            if (gap && i == 10) begin
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk); ld_valid = 1'b0; ld_bit = 1'b1;
                end
            end
            @(negedge clk);
            ld_valid = 1'b1;
            ld_bit = (i < 64) ? key[i] : frame[i-64];
            #1;
            if (i == 1) chk(ks_live == 1'b0, "R2 live low during reload", 32'(ks_live), 0);
            m_load(ld_bit);
        end
        @(negedge clk);
        ld_valid = poke_warm;
        ld_bit = 1'b1;
        #1;
        chk(ld_ready == 1'b0, "R5 ready low in warm-up", 32'(ld_ready), 0);
        repeat (99) @(negedge clk);
        #1;
        chk(ks_live == 1'b0, "R5 live low at 99 steps", 32'(ks_live), 0);
        @(negedge clk);
        ld_valid = 1'b0;
        #1;
        chk(ks_live == 1'b1, "R5 live at 100 steps", 32'(ks_live), 1);
        for (int s = 0; s < 100; s++) m_step();
    endtask

    task automatic stream(input logic [31:0] data, input int n, input bit stall, input bit zero);
        for (int j = 0; j < n; j++) begin
            if (stall && j == 5) begin
                @(negedge clk);
                din = data[j]; din_valid = 1'b1; dout_ready = 1'b0;
                #1;
                chk(din_ready == 1'b0 && dout_valid == 1'b1, "R8 stall handshake",
                    {din_ready, dout_valid}, 32'b01);
                @(negedge clk);
            end else begin
                @(negedge clk);
            end
            din = data[j]; din_valid = 1'b1; dout_ready = 1'b1;
            #1;
            chk(dout == (din ^ m_out()), "R7 R4 R6 keystream bit", 32'(dout), 32'(din ^ m_out()));
            chk(dout_valid == 1'b1 && din_ready == 1'b1, "R8 transfer handshake",
                {din_ready, dout_valid}, 32'b11);
            if (zero) chk(dout == din, "R9 zero state passes data", 32'(dout), 32'(din));
            m_step();
        end
        @(negedge clk);
        din_valid = 1'b0; dout_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(ks_live == 0 && din_ready == 0 && ld_ready == 1, "R1 reset outputs",
            {ks_live, din_ready, ld_ready}, 32'b001);
        din_valid = 1'b1; dout_ready = 1'b1;
        #1;
        chk(dout_valid == 1'b0 && din_ready == 1'b0, "R1 R8 no output before setup",
            {dout_valid, din_ready}, 0);
        din_valid = 1'b0; dout_ready = 1'b0;

        for (int e = 0; e < 4; e++) begin
            // R3 gap in load (e1), R5 load bits ignored in warm-up (e2), R9 zero (e3)
            load(VEC[e][117:54], VEC[e][53:32], e == 1, e == 2);
            stream(VEC[e][31:0], 32, e == 0, e == 3);
        end

        // R1 reset in the middle of streaming, then a fresh load
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk(ks_live == 1'b0 && ld_ready == 1'b1, "R1 mid-run reset", {ks_live, ld_ready}, 32'b01);
        load(VEC[0][117:54], VEC[0][53:32], 1'b0, 1'b0);
        stream(32'h1357_9BDF, 16, 1'b0, 1'b0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule